// File: doc/BRIEF.md
# Speculative Global History with Execution-Time Repair

This block holds the global branch history that a direction predictor indexes with. The history is advanced at prediction time. Each predicted direction enters the register on the clock edge that follows the prediction, so a run of branches predicted on consecutive cycles each sees the directions of the ones before it. With every prediction the block hands back the history value that prediction used. That snapshot travels with the branch down the pipeline.

When the execution stage finds that a branch was mispredicted, it returns the snapshot together with the real outcome. The block rebuilds the speculative history from that snapshot plus the real outcome on the next edge, without waiting for the branch to retire. A second register, the retirement history, advances only on committed branches. A mode input on the repair port makes the speculative history take the retirement history instead, for pipelines that repair at commit. The block does not hold predictor tables or snapshot storage.

Top module: `spec_hist_ckpt`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, spec_hist_o, retire_hist_o and pred_ckpt_o are all zero.
- R2: With pred_valid_i high and fix_valid_i low, spec_hist_o on the next cycle equals the previous value shifted left by one: pred_taken_i enters bit 0 and bit H-1 is dropped.
- R3: pred_ckpt_o always shows the speculative history the current prediction uses, which is the value before that prediction's shift. On back-to-back predictions, each snapshot therefore already holds the bits of every earlier prediction.
- R4: With fix_valid_i high and fix_mode_i low, spec_hist_o on the next cycle equals {fix_ckpt_i[H-2:0], fix_taken_i}.
- R5: When fix_valid_i and pred_valid_i are high in the same cycle, the repair takes effect and the prediction has no effect on spec_hist_o.
- R6: retire_hist_o shifts commit_taken_i into bit 0 on each cycle that commit_valid_i is high. It holds otherwise, whatever happens on the prediction and repair ports.
- R7: With fix_valid_i and fix_mode_i high, spec_hist_o on the next cycle equals retire_hist_o as it stands after that cycle's commit, if there is one.
- R8: With pred_valid_i and fix_valid_i both low, spec_hist_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_valid_i | input | 1 | A prediction is made this cycle |
| pred_taken_i | input | 1 | Predicted direction (1 = taken) |
| pred_ckpt_o | output | H | History used by this cycle's prediction |
| fix_valid_i | input | 1 | Misprediction repair request |
| fix_mode_i | input | 1 | 0 = repair from snapshot, 1 = copy retirement history |
| fix_ckpt_i | input | H | Snapshot carried by the mispredicted branch |
| fix_taken_i | input | 1 | Real outcome of the mispredicted branch |
| commit_valid_i | input | 1 | A branch commits this cycle |
| commit_taken_i | input | 1 | Outcome of the committing branch |
| spec_hist_o | output | H | Speculative history |
| retire_hist_o | output | H | Retirement history |

## Verification
Assertions check on every cycle the next-state relations for spec_hist_o: the shift on a prediction, the snapshot repair, the copy from the retirement history, priority of repair over prediction, and holding when idle. They also check that retire_hist_o moves only on a commit. Only the bench scenarios can show the end-to-end effect: that a chain of predictions yields snapshots that accumulate earlier directions, and that a snapshot taken many cycles earlier restores the exact history once later wrong-path predictions have polluted it. The bench also shows that repair and commit interleave correctly under mixed traffic.

// File: rtl/spec_hist_pkg.sv
package spec_hist_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD   = 2'd0,
    SRC_PRED   = 2'd1,
    SRC_CKPT   = 2'd2,
    SRC_RETIRE = 2'd3
  } spec_src_e;
endpackage

// File: rtl/shist_reg.sv
module shist_reg #(
  parameter int unsigned H = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [H-1:0] d_i,
  output logic [H-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/shist_retire_next.sv
module shist_retire_next #(
  parameter int unsigned H = 8
) (
  input  logic [H-1:0] cur_i,
  input  logic         commit_valid_i,
  input  logic         commit_taken_i,
  output logic         ld_o,
  output logic [H-1:0] nxt_o
);
  always_comb begin
    ld_o  = commit_valid_i;
    nxt_o = commit_valid_i ? {cur_i[H-2:0], commit_taken_i} : cur_i;
  end
endmodule

// File: rtl/shist_spec_next.sv
module shist_spec_next
  import spec_hist_pkg::*;
#(
  parameter int unsigned H = 8
) (
  input  logic [H-1:0] cur_i,
  input  logic         pred_valid_i,
  input  logic         pred_taken_i,
  input  logic         fix_valid_i,
  input  logic         fix_mode_i,
  input  logic [H-1:0] fix_ckpt_i,
  input  logic         fix_taken_i,
  input  logic [H-1:0] retire_nxt_i,
  output logic         ld_o,
  output logic [H-1:0] nxt_o
);
  spec_src_e src;

  // repair outranks prediction
  always_comb begin
    if (fix_valid_i)       src = fix_mode_i ? SRC_RETIRE : SRC_CKPT;
    else if (pred_valid_i) src = SRC_PRED;
    else                   src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_PRED:   nxt_o = {cur_i[H-2:0], pred_taken_i};
      SRC_CKPT:   nxt_o = {fix_ckpt_i[H-2:0], fix_taken_i};
      SRC_RETIRE: nxt_o = retire_nxt_i;
      default:    nxt_o = cur_i;
    endcase
    ld_o = (src != SRC_HOLD);
  end
endmodule

// File: rtl/spec_hist_ckpt.sv
module spec_hist_ckpt #(
  parameter int unsigned H = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pred_valid_i,
  input  logic         pred_taken_i,
  output logic [H-1:0] pred_ckpt_o,
  input  logic         fix_valid_i,
  input  logic         fix_mode_i,
  input  logic [H-1:0] fix_ckpt_i,
  input  logic         fix_taken_i,
  input  logic         commit_valid_i,
  input  logic         commit_taken_i,
  output logic [H-1:0] spec_hist_o,
  output logic [H-1:0] retire_hist_o
);
  localparam int unsigned HM1 = H - 1;

  logic         ret_ld, spec_ld;
  logic [H-1:0] ret_nxt, spec_nxt;

  shist_retire_next #(.H(H)) u_ret_nxt (
    .cur_i          (retire_hist_o),
    .commit_valid_i (commit_valid_i),
    .commit_taken_i (commit_taken_i),
    .ld_o           (ret_ld),
    .nxt_o          (ret_nxt)
  );

  shist_reg #(.H(H)) u_ret_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ret_ld),
    .d_i    (ret_nxt),
    .q_o    (retire_hist_o)
  );

  shist_spec_next #(.H(H)) u_spec_nxt (
    .cur_i        (spec_hist_o),
    .pred_valid_i (pred_valid_i),
    .pred_taken_i (pred_taken_i),
    .fix_valid_i  (fix_valid_i),
    .fix_mode_i   (fix_mode_i),
    .fix_ckpt_i   (fix_ckpt_i),
    .fix_taken_i  (fix_taken_i),
    .retire_nxt_i (ret_nxt),
    .ld_o         (spec_ld),
    .nxt_o        (spec_nxt)
  );

  shist_reg #(.H(H)) u_spec_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (spec_ld),
    .d_i    (spec_nxt),
    .q_o    (spec_hist_o)
  );

  // snapshot is the pre-shift value
  assign pred_ckpt_o = spec_hist_o;

  p_pred_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_i && !fix_valid_i |=>
      spec_hist_o == {$past(spec_hist_o[HM1-1:0]), $past(pred_taken_i)});

  p_ckpt_repair_r4_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_valid_i && !fix_mode_i |=>
      spec_hist_o == {$past(fix_ckpt_i[HM1-1:0]), $past(fix_taken_i)});

  p_retire_copy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_valid_i && fix_mode_i |=> spec_hist_o == retire_hist_o);

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_valid_i && !fix_valid_i |=> $stable(spec_hist_o));

  p_retire_commit_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_valid_i |=> $stable(retire_hist_o));

  p_retire_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_valid_i |=>
      retire_hist_o == {$past(retire_hist_o[HM1-1:0]), $past(commit_taken_i)});
endmodule

// File: tb/spec_hist_ckpt_tb.sv
`timescale 1ns/1ps
module spec_hist_ckpt_tb_top;
  localparam int unsigned H = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pv = 0, pt = 0, fv = 0, fm = 0, ft = 0, cv = 0, ct = 0;
  logic [H-1:0] fc = '0;
  logic [H-1:0] ckpt_o, spec_o, ret_o;

  logic [H-1:0] spec_m = '0, ret_m = '0;
  string        spec_tag = "R1";
  int           n_chk = 0, n_bad = 0;
  logic [H-1:0] saved;

  always #4 clk = ~clk;

  spec_hist_ckpt #(.H(H)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .pred_valid_i(pv), .pred_taken_i(pt), .pred_ckpt_o(ckpt_o),
    .fix_valid_i(fv), .fix_mode_i(fm), .fix_ckpt_i(fc), .fix_taken_i(ft),
    .commit_valid_i(cv), .commit_taken_i(ct),
    .spec_hist_o(spec_o), .retire_hist_o(ret_o)
  );

  function automatic logic [H-1:0] shl(input logic [H-1:0] v, input logic b);
    int unsigned x;
    x = (int'(v) * 2 + int'(b)) % (1 << H);
    return x[H-1:0];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [H-1:0] act, input logic [H-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(spec_tag, "spec_hist_o", spec_o, spec_m);
    chk("R6", "retire_hist_o", ret_o, ret_m);
    chk("R3", "pred_ckpt_o", ckpt_o, spec_m);
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic ipv, input logic ipt, input logic ifv,
                      input logic ifm, input logic [H-1:0] ifc, input logic ift,
                      input logic icv, input logic ict);
    logic [H-1:0] rn;
    pv = ipv; pt = ipt; fv = ifv; fm = ifm; fc = ifc; ft = ift; cv = icv; ct = ict;
    @(posedge clk);
    rn = icv ? shl(ret_m, ict) : ret_m;
    if (ifv && ifm)      begin spec_m = rn;               spec_tag = "R7"; end
    else if (ifv)        begin spec_m = shl(ifc, ift);    spec_tag = ipv ? "R5" : "R4"; end
    else if (ipv)        begin spec_m = shl(spec_m, ipt); spec_tag = "R2"; end
    else                 spec_tag = "R8";
    ret_m = rn;
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "spec in reset", spec_o, '0);
    chk("R1", "retire in reset", ret_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    spec_tag = "R1";
    compare_all();

    // R2/R3: back-to-back predictions accumulate
    step(1,1,0,0,'0,0,0,0);
    step(1,0,0,0,'0,0,0,0);
    saved = ckpt_o;                     // snapshot of branch predicted next
    chk("R3", "snapshot after T,N", saved, 8'b0000_0010);
    step(1,1,0,0,'0,0,0,0);
    step(1,1,0,0,'0,0,0,0);             // wrong-path pollution
    step(1,0,0,0,'0,0,0,0);
    step(0,0,0,0,'0,0,0,0);             // R8 idle
    // R4: repair from old snapshot with outcome 0
    step(0,0,1,0,saved,0,0,0);
    chk("R4", "repaired history", spec_o, 8'b0000_0100);
    // R5: repair beats prediction
    step(1,1,1,0,8'hA5,1,0,0);
    chk("R5", "repair over pred", spec_o, 8'h4B);
    // R6: commits only move retire history
    step(0,0,0,0,'0,0,1,1);
    step(1,0,0,0,'0,0,1,0);
    step(0,0,1,0,8'h0F,1,0,0);
    chk("R6", "retire after T,N", ret_o, 8'b0000_0010);
    // R7: copy retire history including same-cycle commit
    step(1,0,1,1,8'hFF,0,1,1);
    chk("R7", "copy from retire", spec_o, 8'b0000_0101);
    // drop-oldest check: 9 taken predictions saturate
    for (int i = 0; i < H + 1; i++) step(1,1,0,0,'0,0,0,0);
    chk("R2", "saturated history", spec_o, 8'hFF);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[1], r[2] & r[3], r[4], r[15:8], r[5], r[6], r[7]);
    end
    finish_run();
  end
endmodule